// File: doc/BRIEF.md
# Card-Select and System-Control Register Block

This block sits on a synchronous, word-wide register bus that a host processor drives. It holds a 4-bit card-select value. A read of the control-bus word uses that value to pick one of two 16-bit configuration switch banks. The block also provides a system-control word. That word combines the live level of an auto-start switch, two request-out bits that software can write, and two request-in status bits taken from outside the block.

Each bus operation takes one cycle: `bus_en` qualifies the operation and `bus_we` selects a write. Read data is registered and appears on `bus_rdata` one cycle after the read. The two request-out bits drive output pins directly. The two request-in lines pass through a two-flop synchroniser before they reach the read path.

Top module: `cardsel_ctrl_regs`

## Requirements
- R1: A write at byte offset 0x9 stores `bus_wdata[3:0]` as the card select and ignores `bus_wdata[15:4]`.
- R2: After synchronous reset the card select is 0, both request-out pins are 0 and `bus_rdata` is 0.
- R3: A read at offset 0xA while the card select is 12 returns `sw_bank_hi` unchanged, bit for bit.
- R4: A read at offset 0xA while the card select is 14 returns `sw_bank_lo` unchanged, bit for bit.
- R5: A read at offset 0xA with any card select other than 12 or 14 returns 0.
- R6: In a read at offset 0xC, bit 0 equals the level of `autostart_sw` in the cycle of the read.
- R7: A write at offset 0xC loads `bus_wdata[6]` into `req_a_out` and `bus_wdata[5]` into `req_b_out`, visible on the pins in the next cycle. No other bit of the write is stored. Reads at 0xC return `req_b_out` in bit 5 and `req_a_out` in bit 6, and 0 in bits 1-4 and 8-14.
- R8: In a read at offset 0xC, bit 7 shows `req_a_in` and bit 15 shows `req_b_in`, each as sampled two clock edges before the edge that captures the read.
- R9: A write at offset 0xA changes no output and no later read value.
- R10: Read data appears one cycle after the read. `bus_rdata` is 0 in a cycle that follows no read, and it is 0 after a read at any offset other than 0xA or 0xC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus operation valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| sw_bank_lo | input | 16 | Switch banks one and two; an off switch reads 1; position 8 of each byte is its LSB |
| sw_bank_hi | input | 16 | Switch banks three and four, with the same encoding |
| autostart_sw | input | 1 | Live auto-start switch level |
| req_a_in | input | 1 | Asynchronous request A input |
| req_b_in | input | 1 | Asynchronous request B input |
| req_a_out | output | 1 | Request A output |
| req_b_out | output | 1 | Request B output |

## Verification
The assertions assume that `bus_en`, `bus_we`, `bus_addr` and `bus_wdata` are free of X and change only between clock edges. They also assume that at most one operation is presented per cycle. The switch banks and the auto-start switch are treated as plain synchronous inputs. The request-in lines are taken to be asynchronous. The bench therefore drives every input at the falling edge. It holds the request-in lines steady for at least two edges before it predicts their value in a read. The one exception is a directed check on the synchroniser delay.

// File: rtl/cardsel_pkg.sv
package cardsel_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned SEL_W  = 4;

  localparam logic [ADDR_W-1:0] OFS_CARDSEL = 4'h9;
  localparam logic [ADDR_W-1:0] OFS_CTLBUS  = 4'hA;
  localparam logic [ADDR_W-1:0] OFS_SYSCTL  = 4'hC;

  localparam logic [SEL_W-1:0] SEL_BANK_HI = 4'd12;
  localparam logic [SEL_W-1:0] SEL_BANK_LO = 4'd14;

  localparam int unsigned BIT_AUTOSTART = 0;
  localparam int unsigned BIT_REQB_OUT  = 5;
  localparam int unsigned BIT_REQA_OUT  = 6;
  localparam int unsigned BIT_REQA_IN   = 7;
  localparam int unsigned BIT_REQB_IN   = 15;
endpackage

// File: rtl/cs_select_reg.sv
module cs_select_reg #(
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [SEL_W-1:0]  sel
);
  // R1: only the low nibble is retained
  always_ff @(posedge clk) begin
    if (rst)        sel <= '0;
    else if (wr_en) sel <= wdata[SEL_W-1:0];
  end
endmodule

// File: rtl/cs_sync_bank.sv
module cs_sync_bank #(
  parameter int unsigned N      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], din[i]};
    end
    assign dout[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/cs_sysctrl_reg.sv
module cs_sysctrl_reg #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned A_BIT   = 6,
  parameter int unsigned B_BIT   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              req_a,
  output logic              req_b
);
  // R7: masked write, only the two request-out bits are stored
  always_ff @(posedge clk) begin
    if (rst) begin
      req_a <= 1'b0;
      req_b <= 1'b0;
    end else if (wr_en) begin
      req_a <= wdata[A_BIT];
      req_b <= wdata[B_BIT];
    end
  end
endmodule

// File: rtl/cs_read_mux.sv
module cs_read_mux
  import cardsel_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] bank_lo,
  input  logic [DATA_W-1:0] bank_hi,
  input  logic              autostart,
  input  logic              req_a_out,
  input  logic              req_b_out,
  input  logic              req_a_sync,
  input  logic              req_b_sync,
  output logic [DATA_W-1:0] rword
);
  logic [DATA_W-1:0] ctl_word;
  logic [DATA_W-1:0] sys_word;

  always_comb begin
    unique case (sel)
      SEL_BANK_HI: ctl_word = bank_hi;
      SEL_BANK_LO: ctl_word = bank_lo;
      default:     ctl_word = '0;
    endcase
  end

  always_comb begin
    sys_word                = '0;
    sys_word[BIT_AUTOSTART] = autostart;
    sys_word[BIT_REQB_OUT]  = req_b_out;
    sys_word[BIT_REQA_OUT]  = req_a_out;
    sys_word[BIT_REQA_IN]   = req_a_sync;
    sys_word[BIT_REQB_IN]   = req_b_sync;
  end

  always_comb begin
    if (addr == OFS_CTLBUS)      rword = ctl_word;
    else if (addr == OFS_SYSCTL) rword = sys_word;
    else                         rword = '0;
  end
endmodule

// File: rtl/cardsel_ctrl_regs.sv
module cardsel_ctrl_regs
  import cardsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] sw_bank_lo,
  input  logic [DATA_W-1:0] sw_bank_hi,
  input  logic              autostart_sw,
  input  logic              req_a_in,
  input  logic              req_b_in,
  output logic              req_a_out,
  output logic              req_b_out
);
  logic              wr_cardsel;
  logic              wr_sysctl;
  logic              rd_strobe;
  logic [SEL_W-1:0]  card_sel;
  logic [1:0]        req_sync;
  logic [DATA_W-1:0] rd_word;

  assign wr_cardsel = bus_en && bus_we && (bus_addr == OFS_CARDSEL);
  assign wr_sysctl  = bus_en && bus_we && (bus_addr == OFS_SYSCTL);
  assign rd_strobe  = bus_en && !bus_we;

  cs_select_reg #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_sel (
    .clk(clk), .rst(rst), .wr_en(wr_cardsel), .wdata(bus_wdata), .sel(card_sel)
  );

  cs_sync_bank #(.N(2), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .din({req_b_in, req_a_in}), .dout(req_sync)
  );

  cs_sysctrl_reg #(.DATA_W(DATA_W), .A_BIT(BIT_REQA_OUT), .B_BIT(BIT_REQB_OUT)) u_sys (
    .clk(clk), .rst(rst), .wr_en(wr_sysctl), .wdata(bus_wdata),
    .req_a(req_a_out), .req_b(req_b_out)
  );

  cs_read_mux u_mux (
    .addr(bus_addr), .sel(card_sel), .bank_lo(sw_bank_lo), .bank_hi(sw_bank_hi),
    .autostart(autostart_sw), .req_a_out(req_a_out), .req_b_out(req_b_out),
    .req_a_sync(req_sync[0]), .req_b_sync(req_sync[1]), .rword(rd_word)
  );

  // R10: registered read data, zero when no read
  always_ff @(posedge clk) begin
    if (rst)            bus_rdata <= '0;
    else if (rd_strobe) bus_rdata <= rd_word;
    else                bus_rdata <= '0;
  end
endmodule

// File: rtl/cardsel_ctrl_regs_chk.sv
module cardsel_ctrl_regs_chk
  import cardsel_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] sw_bank_lo,
  input logic [DATA_W-1:0] sw_bank_hi,
  input logic              autostart_sw,
  input logic              req_a_out,
  input logic              req_b_out,
  input logic [SEL_W-1:0]  card_sel
);
  logic rd_ctl, rd_sys, wr_sys, wr_sel;
  assign rd_ctl = bus_en && !bus_we && bus_addr == OFS_CTLBUS;
  assign rd_sys = bus_en && !bus_we && bus_addr == OFS_SYSCTL;
  assign wr_sys = bus_en && bus_we && bus_addr == OFS_SYSCTL;
  assign wr_sel = bus_en && bus_we && bus_addr == OFS_CARDSEL;

  a_r1_sel_low_nibble: assert property (@(posedge clk) disable iff (rst)
    wr_sel |=> card_sel == $past(bus_wdata[SEL_W-1:0]));

  a_r3_bank_hi: assert property (@(posedge clk) disable iff (rst)
    (rd_ctl && card_sel == SEL_BANK_HI) |=> bus_rdata == $past(sw_bank_hi));

  a_r4_bank_lo: assert property (@(posedge clk) disable iff (rst)
    (rd_ctl && card_sel == SEL_BANK_LO) |=> bus_rdata == $past(sw_bank_lo));

  a_r5_other_sel_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_ctl && card_sel != SEL_BANK_HI && card_sel != SEL_BANK_LO) |=> bus_rdata == '0);

  a_r6_autostart_live: assert property (@(posedge clk) disable iff (rst)
    rd_sys |=> bus_rdata[BIT_AUTOSTART] == $past(autostart_sw));

  a_r7_masked_write: assert property (@(posedge clk) disable iff (rst)
    wr_sys |=> (req_a_out == $past(bus_wdata[BIT_REQA_OUT]) &&
                req_b_out == $past(bus_wdata[BIT_REQB_OUT])));

  a_r9_outs_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_sys |=> ($stable(req_a_out) && $stable(req_b_out)));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !(bus_en && !bus_we) |=> bus_rdata == '0);
endmodule

bind cardsel_ctrl_regs cardsel_ctrl_regs_chk u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sw_bank_lo(sw_bank_lo),
  .sw_bank_hi(sw_bank_hi), .autostart_sw(autostart_sw), .req_a_out(req_a_out),
  .req_b_out(req_b_out), .card_sel(card_sel)
);

// File: tb/tb_cardsel_ctrl_regs.sv
`timescale 1ns/1ps
module tb_cardsel_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_en, bus_we;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [15:0] sw_bank_lo, sw_bank_hi;
  logic        autostart_sw, req_a_in, req_b_in, req_a_out, req_b_out;

  int checks = 0;
  int errors = 0;
  logic [3:0] m_sel;
  logic       m_a, m_b;

  always #2.5 clk = ~clk;

  cardsel_ctrl_regs dut (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [3:0] a);
    logic [15:0] w = '0;
    if (a == 4'hA) begin
      if (m_sel == 4'd12)      w = sw_bank_hi;
      else if (m_sel == 4'd14) w = sw_bank_lo;
    end else if (a == 4'hC) begin
      w[0] = autostart_sw; w[5] = m_b; w[6] = m_a;
      w[7] = req_a_in; w[15] = req_b_in;
    end
    return w;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    if (a == 4'h9) m_sel = d[3:0];
    if (a == 4'hC) begin m_a = d[6]; m_b = d[5]; end
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d, output logic [15:0] e);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    e = exp_read(a);
    @(negedge clk);
    bus_en = 0;
    d = bus_rdata;
  endtask

  task automatic settle_req(input logic a, input logic b);
    @(negedge clk);
    req_a_in = a; req_b_in = b;
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] d, e;
    void'($urandom(32'd4711));
    rst = 1; bus_en = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    sw_bank_lo = 16'hA5C3; sw_bank_hi = 16'h3C5A; autostart_sw = 0;
    req_a_in = 0; req_b_in = 0;
    m_sel = 0; m_a = 0; m_b = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R2 reset state
    check("R2 rdata", bus_rdata, 16'h0);
    check("R2 req outs", {14'h0, req_a_out, req_b_out}, 16'h0);
    rd(4'hA, d, e); check("R2 sel=0 reads zero", d, 16'h0);

    // R1/R3 upper bits ignored: 0xFFFC -> sel 12
    wr(4'h9, 16'hFFFC);
    rd(4'hA, d, e); check("R1 R3 bank hi", d, 16'h3C5A);
    // R4
    wr(4'h9, 16'h000E);
    rd(4'hA, d, e); check("R4 bank lo", d, 16'hA5C3);
    // R5 neighbours
    wr(4'h9, 16'h000D);
    rd(4'hA, d, e); check("R5 sel 13", d, 16'h0);
    wr(4'h9, 16'h00F0);
    rd(4'hA, d, e); check("R5 sel 0 after high write", d, 16'h0);

    // R6 autostart live
    autostart_sw = 1;
    rd(4'hC, d, e); check("R6 autostart on", d, 16'h0001);
    autostart_sw = 0;
    rd(4'hC, d, e); check("R6 autostart off", d, 16'h0000);

    // R7 masked write
    wr(4'hC, 16'hFFFF);
    check("R7 pins after all-ones", {14'h0, req_a_out, req_b_out}, 16'h0003);
    rd(4'hC, d, e); check("R7 readback", d, 16'h0060);
    wr(4'hC, 16'h0020);
    check("R7 only B", {14'h0, req_a_out, req_b_out}, 16'h0001);

    // R8 synchroniser delay
    @(negedge clk); req_a_in = 1; req_b_in = 1;
    rd(4'hC, d, e); check("R8 not yet visible", d & 16'h8080, 16'h0000);
    rd(4'hC, d, e); check("R8 visible after sync", d & 16'h8080, 16'h8080);

    // R9 control bus write ignored
    wr(4'h9, 16'h000C);
    wr(4'hA, 16'hFFFF);
    check("R9 outs unchanged", {14'h0, req_a_out, req_b_out}, 16'h0001);
    rd(4'hA, d, e); check("R9 read unchanged", d, 16'h3C5A);

    // R10 idle and other offsets
    @(negedge clk); check("R10 idle zero", bus_rdata, 16'h0);
    rd(4'h9, d, e); check("R10 offset 9 reads zero", d, 16'h0);
    rd(4'h3, d, e); check("R10 offset 3 reads zero", d, 16'h0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 5);
      sw_bank_lo = 16'($urandom); sw_bank_hi = 16'($urandom);
      autostart_sw = 1'($urandom);
      case (op)
        0: wr(4'h9, 16'($urandom) | (($urandom_range(0,1) != 0) ? 16'h000C : 16'h0));
        1: begin rd(4'hA, d, e); check("R3 R4 R5 random ctl read", d, e); end
        2: wr(4'hC, 16'($urandom));
        3: begin rd(4'hC, d, e); check("R6 R7 R8 random sys read", d, e); end
        4: wr(4'hA, 16'($urandom));
        default: begin
          logic [3:0] a = 4'($urandom);
          rd(a, d, e); check("R10 random offset read", d, e);
        end
      endcase
      if (i % 37 == 0) settle_req(1'($urandom), 1'($urandom));
      check("R7 R9 random pins", {14'h0, req_a_out, req_b_out}, {14'h0, m_a, m_b});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule